// File: doc/BRIEF.md
# Input Line Timing Generator

This block produces the horizontal reference for the pixel input side of a video encoder. It runs on the input pixel clock. Each line begins with a leading (falling) edge of an active-low sync strobe, which stays low for a fixed number of clocks. A pixel window opens a programmable number of clocks after that edge and stays open for a programmable number of pixels. While the window is open, a pixel index counts upward from zero.

The line length can carry a fractional part. Once per line, an 8-bit fraction is added into an 8-bit accumulator. Every carry out of that accumulator makes the line just started one clock longer. The average line length is therefore the whole-number period plus the fraction divided by 256. All four setting inputs are captured only at a line's leading edge, so a value written mid-line changes nothing until the next line.

Top module: `line_timing_gen`

## Requirements
- R1: While reset is asserted, `hsync_n` is 1, `active` is 0 and `pix_idx` is 0. The first clock edge after reset is released starts a line, so `hsync_n` is 0 in the cycle that follows. Reset clears the fraction accumulator.
- R2: With `cfg_frac` at 0, consecutive falling edges of `hsync_n` are exactly `cfg_period` clocks apart. This holds for any period above `SYNC_WIDTH`.
- R3: `hsync_n` is low for exactly `SYNC_WIDTH` clocks (default 64), starting at each line's leading edge.
- R4: Number the clocks of a line from 0 at the leading edge. `active` first goes high at position `cfg_offset`.
- R5: `active` stays high for `cfg_count` consecutive clocks. During that time `pix_idx` runs 0, 1, 2 and so on, one step per clock. `pix_idx` is 0 whenever `active` is low.
- R6: If `cfg_offset + cfg_count` exceeds the line length, the window closes at the next leading edge, so it lasts (line length − `cfg_offset`) clocks.
- R7: A `cfg_count` of 0 keeps `active` low for the whole line.
- R8: At each line start, `cfg_frac` is added to the 8-bit accumulator. A carry out adds one clock to that line, and a fraction of 0 never lengthens a line. After reset, a fraction of 0x80 gives lines of P, P+1, P, P+1. A fraction of 0x40 lengthens only lines 4 and 8 of the first eight.
- R9: The period, offset, count and fraction are sampled only at a line's leading edge. A value applied after a line has started first affects the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_period | input | 11 | Whole-number line period in clocks |
| cfg_offset | input | 10 | Clocks from the leading edge to the first active pixel |
| cfg_count | input | 11 | Active pixels per line |
| cfg_frac | input | 8 | Fractional period, in units of 1/256 clock |
| hsync_n | output | 1 | Active-low horizontal sync strobe |
| active | output | 1 | High during the active pixel window |
| pix_idx | output | 11 | Index of the current active pixel, 0 when inactive |

## Verification
The bench applies new settings just after a leading edge. It then checks that the running line keeps the old period and offset, and that the following line uses the new ones. A design that latched settings continuously would fail that check with an early or late edge. Window truncation is checked by setting an offset plus count past the line end: a design that did not truncate would carry `active` into the sync of the next line, and a design whose offset arithmetic wrapped would give a short or missing window. The fraction sequences for 0x80 and 0x40 are checked line by line from reset. They catch a wrong initial accumulator value, and they catch the extra clock being applied to the wrong line.

// File: rtl/line_timing_pkg.sv
package line_timing_pkg;
    localparam int unsigned LT_PERIOD_W  = 11;
    localparam int unsigned LT_OFFSET_W  = 10;
    localparam int unsigned LT_COUNT_W   = 11;
    localparam int unsigned LT_FRAC_W    = 8;
    localparam int unsigned LT_SYNC_W    = 64;
endpackage

// File: rtl/lt_frac_acc.sv
module lt_frac_acc
    import line_timing_pkg::*;
#(
    parameter int unsigned FRAC_W = LT_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [FRAC_W-1:0] cfg_frac,
    output logic              extra
);
    typedef struct packed {
        logic [FRAC_W-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [FRAC_W:0] sum;

    always_comb begin
        sum   = {1'b0, st_q.acc} + {1'b0, cfg_frac};
        extra = sum[FRAC_W];
        st_d  = st_q;
        if (step) begin
            st_d.acc = sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q.acc)); // R8
endmodule

// File: rtl/lt_line_ctr.sv
module lt_line_ctr
    import line_timing_pkg::*;
#(
    parameter int unsigned PERIOD_W = LT_PERIOD_W,
    parameter int unsigned OFFSET_W = LT_OFFSET_W,
    parameter int unsigned COUNT_W  = LT_COUNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [OFFSET_W-1:0] cfg_offset,
    input  logic [COUNT_W-1:0]  cfg_count,
    input  logic                extra,
    output logic                line_start,
    output logic                run,
    output logic [PERIOD_W:0]   pos,
    output logic [OFFSET_W-1:0] off,
    output logic [COUNT_W-1:0]  cnt
);
    localparam int unsigned LW = PERIOD_W + 1;

    typedef struct packed {
        logic                run;
        logic [LW-1:0]       pos;
        logic [LW-1:0]       len;
        logic [OFFSET_W-1:0] off;
        logic [COUNT_W-1:0]  cnt;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        line_start = !st_q.run || ((st_q.pos + LW'(1)) >= st_q.len);
        st_d = st_q;
        if (line_start) begin
            st_d.run = 1'b1;
            st_d.pos = '0;
            st_d.len = LW'(cfg_period) + LW'(extra);
            st_d.off = cfg_offset;
            st_d.cnt = cfg_count;
        end else begin
            st_d.pos = st_q.pos + LW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run = st_q.run;
    assign pos = st_q.pos;
    assign off = st_q.off;
    assign cnt = st_q.cnt;

    AST_POS_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && st_q.len != '0) |-> (st_q.pos < st_q.len)); // R2
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !line_start) |=> ($stable(st_q.off) && $stable(st_q.cnt) && $stable(st_q.len))); // R9
endmodule

// File: rtl/lt_window_dec.sv
module lt_window_dec
    import line_timing_pkg::*;
#(
    parameter int unsigned PERIOD_W   = LT_PERIOD_W,
    parameter int unsigned OFFSET_W   = LT_OFFSET_W,
    parameter int unsigned COUNT_W    = LT_COUNT_W,
    parameter int unsigned SYNC_WIDTH = LT_SYNC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic [PERIOD_W:0]   pos,
    input  logic [OFFSET_W-1:0] off,
    input  logic [COUNT_W-1:0]  cnt,
    output logic                hsync_n,
    output logic                active,
    output logic [COUNT_W-1:0]  pix_idx
);
    localparam int unsigned LW = PERIOD_W + 1;
    localparam int unsigned EW = LW + 2;
    localparam logic [LW-1:0] SYNC_LIM = LW'(SYNC_WIDTH);

    logic [EW-1:0] pos_e, win_lo, win_hi;

    always_comb begin
        pos_e   = EW'(pos);
        win_lo  = EW'(off);
        win_hi  = EW'(off) + EW'(cnt);
        hsync_n = !(run && (pos < SYNC_LIM));
        active  = run && (pos_e >= win_lo) && (pos_e < win_hi);
        pix_idx = active ? COUNT_W'(pos_e - win_lo) : '0;
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (pix_idx < cnt)); // R5
    AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !active); // R7
endmodule

// File: rtl/line_timing_gen.sv
module line_timing_gen
    import line_timing_pkg::*;
#(
    parameter int unsigned PERIOD_W   = LT_PERIOD_W,
    parameter int unsigned OFFSET_W   = LT_OFFSET_W,
    parameter int unsigned COUNT_W    = LT_COUNT_W,
    parameter int unsigned FRAC_W     = LT_FRAC_W,
    parameter int unsigned SYNC_WIDTH = LT_SYNC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic [OFFSET_W-1:0] cfg_offset,
    input  logic [COUNT_W-1:0]  cfg_count,
    input  logic [FRAC_W-1:0]   cfg_frac,
    output logic                hsync_n,
    output logic                active,
    output logic [COUNT_W-1:0]  pix_idx
);
    logic                line_start;
    logic                extra;
    logic                run;
    logic [PERIOD_W:0]   pos;
    logic [OFFSET_W-1:0] off;
    logic [COUNT_W-1:0]  cnt;

    lt_frac_acc #(.FRAC_W(FRAC_W)) frac_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (line_start),
        .cfg_frac (cfg_frac),
        .extra    (extra)
    );

    lt_line_ctr #(
        .PERIOD_W (PERIOD_W),
        .OFFSET_W (OFFSET_W),
        .COUNT_W  (COUNT_W)
    ) ctr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_period),
        .cfg_offset (cfg_offset),
        .cfg_count  (cfg_count),
        .extra      (extra),
        .line_start (line_start),
        .run        (run),
        .pos        (pos),
        .off        (off),
        .cnt        (cnt)
    );

    lt_window_dec #(
        .PERIOD_W   (PERIOD_W),
        .OFFSET_W   (OFFSET_W),
        .COUNT_W    (COUNT_W),
        .SYNC_WIDTH (SYNC_WIDTH)
    ) dec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .pos     (pos),
        .off     (off),
        .cnt     (cnt),
        .hsync_n (hsync_n),
        .active  (active),
        .pix_idx (pix_idx)
    );

    AST_LEAD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !hsync_n); // R3
    AST_NO_WINDOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!active && hsync_n)); // R1
endmodule

// File: tb/line_timing_gen_tb_top.sv
module line_timing_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] cfg_period = 11'd200;
    logic [9:0]  cfg_offset = 10'd80;
    logic [10:0] cfg_count = 11'd100;
    logic [7:0]  cfg_frac = 8'd0;
    logic        hsync_n;
    logic        active;
    logic [10:0] pix_idx;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    line_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_offset(cfg_offset),
        .cfg_count(cfg_count), .cfg_frac(cfg_frac), .hsync_n(hsync_n),
        .active(active), .pix_idx(pix_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int p, input int o, input int c, input int f);
        cfg_period = 11'(p);
        cfg_offset = 10'(o);
        cfg_count  = 11'(c);
        cfg_frac   = 8'(f);
    endtask

    // Starts at a negedge at position 0 of a line; returns at position 0 of the next.
    task automatic measure(output int len, output int sync_lo, output int act_first,
                           output int act_n, output bit idx_ok);
        int pos = 0;
        bit prev_h = 1'b0;
        sync_lo = 0; act_first = -1; act_n = 0; idx_ok = 1'b1;
        while (1) begin
            if (pos > 0 && !hsync_n && prev_h) break;
            if (pos > 5000) break;
            if (!hsync_n) sync_lo++;
            if (active) begin
                if (act_first < 0) act_first = pos;
                if (int'(pix_idx) != pos - act_first) idx_ok = 1'b0;
                act_n++;
            end else if (pix_idx != 11'd0) begin
                idx_ok = 1'b0;
            end
            prev_h = hsync_n;
            @(negedge clk);
            pos++;
        end
        len = pos;
    endtask

    task automatic do_reset(input int p, input int o, input int c, input int f);
        @(negedge clk);
        rst_n = 1'b0;
        set_cfg(p, o, c, f);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        set_cfg(200, 80, 100, 0);
        repeat (3) @(negedge clk);
        chk(hsync_n == 1'b1, "R1 hsync_n in reset", int'(hsync_n), 1);
        chk(active == 1'b0, "R1 active in reset", int'(active), 0);
        chk(pix_idx == 11'd0, "R1 pix_idx in reset", int'(pix_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hsync_n == 1'b0, "R1 first edge after release", int'(hsync_n), 0);
    endtask

    task automatic t_basic();
        int len, sl, af, an; bit ok;
        measure(len, sl, af, an, ok);
        chk(len == 200, "R2 period", len, 200);
        chk(sl == 64, "R3 sync width", sl, 64);
        chk(af == 80, "R4 window start", af, 80);
        chk(an == 100, "R5 window length", an, 100);
        chk(ok, "R5 pixel index", int'(ok), 1);
    endtask

    task automatic t_change();
        int len, sl, af, an; bit ok;
        set_cfg(300, 10, 20, 0);
        measure(len, sl, af, an, ok);
        chk(len == 200, "R9 running line keeps period", len, 200);
        chk(af == 80, "R9 running line keeps offset", af, 80);
        measure(len, sl, af, an, ok);
        chk(len == 300, "R9 new period next line", len, 300);
        chk(af == 10, "R4 offset inside sync", af, 10);
        chk(an == 20, "R5 short window", an, 20);
        chk(ok, "R5 pixel index short", int'(ok), 1);
    endtask

    task automatic t_trunc();
        int len, sl, af, an; bit ok;
        set_cfg(150, 100, 200, 0);
        measure(len, sl, af, an, ok);
        measure(len, sl, af, an, ok);
        chk(len == 150, "R6 period", len, 150);
        chk(af == 100, "R6 window start", af, 100);
        chk(an == 50, "R6 truncated window", an, 50);
        chk(ok, "R6 index on truncated window", int'(ok), 1);
    endtask

    task automatic t_zero();
        int len, sl, af, an; bit ok;
        set_cfg(150, 20, 0, 0);
        measure(len, sl, af, an, ok);
        measure(len, sl, af, an, ok);
        chk(an == 0, "R7 zero count window", an, 0);
        chk(ok, "R7 index stays zero", int'(ok), 1);
    endtask

    task automatic t_frac_half();
        int len, sl, af, an; bit ok;
        do_reset(180, 20, 30, 8'h80);
        for (int i = 0; i < 4; i++) begin
            int exp = (i % 2 == 1) ? 181 : 180;
            measure(len, sl, af, an, ok);
            chk(len == exp, "R8 half fraction line", len, exp);
        end
    endtask

    task automatic t_frac_quarter();
        int len, sl, af, an; bit ok;
        do_reset(180, 20, 30, 8'h40);
        for (int i = 0; i < 8; i++) begin
            int exp = (i == 3 || i == 7) ? 181 : 180;
            measure(len, sl, af, an, ok);
            chk(len == exp, "R8 quarter fraction line", len, exp);
        end
    endtask

    initial begin
        t_reset();
        t_basic();
        t_change();
        t_trunc();
        t_zero();
        t_frac_half();
        t_frac_quarter();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule